// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block holds the activity state of one processor core and decides when a sleeping core resumes. The core can be running, halted, in a monitor wait, in a monitor wait that treats maskable interrupts as enabled, or parked until a startup message arrives. The execution pipeline requests a sleep state. The controller then watches the interrupt lines, the latched NMI/SMI/INIT events, the monitor-hit line and startup messages, and returns the core to running when a qualified cause appears.

On a wake it pulses a wake strobe and a strobe that clears the interrupt-inhibit shadow. On a wake by an event from a monitor wait it also pulses a strobe that disarms the address monitor. A startup message releases a parked core. The controller then loads a code segment selector equal to the 8-bit vector times 0x100 and an instruction offset of zero, and it unmasks the three special events. NMI, SMI and INIT requests are latched in pending bits. Each event has a mask bit. The core sets mask bits through a set port and clears pending bits through an acknowledge port.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: In the parked state (code 4) the state stays parked on every cycle without a startup message, whatever interrupts, NMI, SMI or INIT are pending.
- R2: In halt (1) or monitor wait (2), a maskable or local-controller interrupt wakes the core only when `if_flag` is 1. In the interrupt-forced monitor wait (3) it wakes the core whatever `if_flag` is.
- R3: A pending and unmasked NMI, SMI or INIT wakes the core from states 1, 2 or 3 whatever `if_flag` is. A pending event whose mask bit is set does not wake the core.
- R4: Every wake sets the state to running (0). In the same cycle `wake` pulses for exactly one cycle, and `clr_inhibit` pulses with it on every wake except a startup release.
- R5: `mon_reset` pulses with `wake` when an interrupt or event wakes the core from state 2 or 3. It stays 0 on a wake from halt.
- R6: `mon_hit` in state 2 or 3 returns the core to running with `wake` and `clr_inhibit` and without `mon_reset`, with no interrupt pending. In halt, `mon_hit` is ignored.
- R7: `sipi_valid` in the parked state sets the state to running and pulses `start_load` and `wake`. It sets `start_cs` to `sipi_vec` shifted left by 8 and `start_ip` to 0, and clears all three mask bits.
- R8: `sipi_valid` in any other state pulses `sipi_ignored` and changes neither the state nor `start_load`.
- R9: Pending bit order is [0] NMI, [1] SMI, [2] INIT, and the mask bits use the same order. An INIT request is latched only while its mask bit is 0. NMI and SMI requests are always latched. `evt_ack` clears a pending bit.
- R10: The state code is 0 running, 1 halt, 2 monitor wait, 3 interrupt-forced monitor wait and 4 parked. After reset the state is 0, all strobes are 0, and the pending and mask bits are 0. In running, `sleep_req` moves the state to `sleep_kind` (1 to 4) at the next edge.
- R11: When several wake causes are present in the same cycle, exactly one transition to running occurs, and `wake` is 0 again on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter the state given by sleep_kind |
| sleep_kind | input | 3 | Target sleep state code (1 to 4) |
| intr_req | input | 1 | Maskable external interrupt pending (level) |
| lic_req | input | 1 | Local interrupt controller request (level) |
| if_flag | input | 1 | Interrupt-enable flag of the core |
| nmi_req | input | 1 | NMI request pulse |
| smi_req | input | 1 | SMI request pulse |
| init_req | input | 1 | INIT request pulse |
| evt_ack | input | 3 | Clear pending bits {INIT, SMI, NMI} |
| mask_set | input | 3 | Set mask bits {INIT, SMI, NMI} |
| mon_hit | input | 1 | Address monitor was written |
| sipi_valid | input | 1 | Startup message present |
| sipi_vec | input | 8 | Startup vector |
| state | output | 3 | Current activity state code |
| wake | output | 1 | One-cycle pulse on return to running |
| clr_inhibit | output | 1 | One-cycle strobe to clear the inhibit shadow |
| mon_reset | output | 1 | One-cycle strobe to disarm the monitor |
| start_load | output | 1 | One-cycle strobe to load start_cs and start_ip |
| start_cs | output | 16 | Code segment selector for startup |
| start_ip | output | 32 | Instruction offset for startup |
| sipi_ignored | output | 1 | Startup message arrived outside the parked state |
| evt_pend | output | 3 | Pending bits {INIT, SMI, NMI} |
| evt_mask | output | 3 | Mask bits {INIT, SMI, NMI} |

## Verification
Level inputs (interrupts, `if_flag`, `mon_hit`, `sipi_valid`, `sleep_req`) act at the next rising edge. So the state and every strobe they cause are due one cycle after they are driven. NMI, SMI and INIT pass through a pending register first: the pending bit is due one cycle after the request, and a wake it causes is due one cycle after that. The bench drives on the falling edge and samples on the falling edge after the edge where the result is due. It looks one more cycle later to confirm that each strobe has dropped.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_HALT       = 3'd1,
    ST_MWAIT      = 3'd2,
    ST_MWAIT_IRQ  = 3'd3,
    ST_WAIT_START = 3'd4
  } act_state_t;

  localparam int EV_NMI  = 0;
  localparam int EV_SMI  = 1;
  localparam int EV_INIT = 2;
  localparam int N_EVT   = 3;
endpackage

// File: rtl/swc_event_latch.sv
module swc_event_latch
  import swc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] req,
  input  logic [N_EVT-1:0] ack,
  input  logic [N_EVT-1:0] mask_set,
  input  logic             unmask_all,
  output logic [N_EVT-1:0] pend_q,
  output logic [N_EVT-1:0] mask_q
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    // only INIT is refused while masked; the others always latch
    localparam bit GATED = (i == EV_INIT);
    logic take;
    assign take = req[i] & (GATED ? ~mask_q[i] : 1'b1);

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        if (take)        pend_q[i] <= 1'b1;
        else if (ack[i]) pend_q[i] <= 1'b0;
        if (unmask_all)  mask_q[i] <= 1'b0;
        else             mask_q[i] <= mask_q[i] | mask_set[i];
      end
    end
  end
endmodule

// File: rtl/swc_wake_qual.sv
module swc_wake_qual
  import swc_pkg::*;
(
  input  act_state_t       cur,
  input  logic             intr_req,
  input  logic             lic_req,
  input  logic             if_flag,
  input  logic [N_EVT-1:0] pend,
  input  logic [N_EVT-1:0] mask,
  input  logic             mon_hit,
  input  logic             sipi_valid,
  output logic             evt_wake,
  output logic             mhit_wake,
  output logic             start_go,
  output logic             start_ign
);
  logic in_mwait, sleeping, irq_ok, live_evt;

  always_comb begin
    in_mwait  = (cur == ST_MWAIT) || (cur == ST_MWAIT_IRQ);
    sleeping  = in_mwait || (cur == ST_HALT);
    irq_ok    = (intr_req | lic_req) & (if_flag | (cur == ST_MWAIT_IRQ));
    live_evt  = |(pend & ~mask);
    evt_wake  = sleeping & (irq_ok | live_evt);
    mhit_wake = in_mwait & mon_hit;
    start_go  = sipi_valid & (cur == ST_WAIT_START);
    start_ign = sipi_valid & (cur != ST_WAIT_START);
  end
endmodule

// File: rtl/swc_state_fsm.sv
module swc_state_fsm
  import swc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int SEL_SHIFT = 8,
  parameter int IP_W      = 32,
  localparam int CS_W     = VEC_W + SEL_SHIFT
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic [2:0]       sleep_kind,
  input  logic             evt_wake,
  input  logic             mhit_wake,
  input  logic             start_go,
  input  logic             start_ign,
  input  logic [VEC_W-1:0] sipi_vec,
  output act_state_t       cur,
  output logic             wake,
  output logic             clr_inhibit,
  output logic             mon_reset,
  output logic             start_load,
  output logic [CS_W-1:0]  start_cs,
  output logic [IP_W-1:0]  start_ip,
  output logic             sipi_ignored
);
  logic kind_ok, from_mwait;

  always_comb begin
    kind_ok    = (sleep_kind >= 3'd1) && (sleep_kind <= 3'd4);
    from_mwait = (cur == ST_MWAIT) || (cur == ST_MWAIT_IRQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur          <= ST_RUN;
      wake         <= 1'b0;
      clr_inhibit  <= 1'b0;
      mon_reset    <= 1'b0;
      start_load   <= 1'b0;
      start_cs     <= '0;
      start_ip     <= '0;
      sipi_ignored <= 1'b0;
    end else begin
      wake         <= 1'b0;
      clr_inhibit  <= 1'b0;
      mon_reset    <= 1'b0;
      start_load   <= 1'b0;
      sipi_ignored <= start_ign;
      if (evt_wake || mhit_wake) begin
        cur         <= ST_RUN;
        wake        <= 1'b1;
        clr_inhibit <= 1'b1;
        mon_reset   <= evt_wake & from_mwait;
      end else if (start_go) begin
        cur        <= ST_RUN;
        wake       <= 1'b1;
        start_load <= 1'b1;
        start_cs   <= {sipi_vec, {SEL_SHIFT{1'b0}}};
        start_ip   <= '0;
      end else if (cur == ST_RUN && sleep_req && kind_ok) begin
        cur <= act_state_t'(sleep_kind);
      end
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int SEL_SHIFT = 8,
  parameter int IP_W      = 32,
  localparam int CS_W     = VEC_W + SEL_SHIFT
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic [2:0]       sleep_kind,
  input  logic             intr_req,
  input  logic             lic_req,
  input  logic             if_flag,
  input  logic             nmi_req,
  input  logic             smi_req,
  input  logic             init_req,
  input  logic [2:0]       evt_ack,
  input  logic [2:0]       mask_set,
  input  logic             mon_hit,
  input  logic             sipi_valid,
  input  logic [VEC_W-1:0] sipi_vec,
  output logic [2:0]       state,
  output logic             wake,
  output logic             clr_inhibit,
  output logic             mon_reset,
  output logic             start_load,
  output logic [CS_W-1:0]  start_cs,
  output logic [IP_W-1:0]  start_ip,
  output logic             sipi_ignored,
  output logic [2:0]       evt_pend,
  output logic [2:0]       evt_mask
);
  act_state_t       cur;
  logic [N_EVT-1:0] req;
  logic             evt_wake, mhit_wake, start_go, start_ign;

  always_comb begin
    req          = '0;
    req[EV_NMI]  = nmi_req;
    req[EV_SMI]  = smi_req;
    req[EV_INIT] = init_req;
  end

  swc_event_latch u_evt (
    .clk(clk), .rst(rst), .req(req), .ack(evt_ack), .mask_set(mask_set),
    .unmask_all(start_go), .pend_q(evt_pend), .mask_q(evt_mask)
  );

  swc_wake_qual u_qual (
    .cur(cur), .intr_req(intr_req), .lic_req(lic_req), .if_flag(if_flag),
    .pend(evt_pend), .mask(evt_mask), .mon_hit(mon_hit), .sipi_valid(sipi_valid),
    .evt_wake(evt_wake), .mhit_wake(mhit_wake), .start_go(start_go),
    .start_ign(start_ign)
  );

  swc_state_fsm #(.VEC_W(VEC_W), .SEL_SHIFT(SEL_SHIFT), .IP_W(IP_W)) u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_kind(sleep_kind),
    .evt_wake(evt_wake), .mhit_wake(mhit_wake), .start_go(start_go),
    .start_ign(start_ign), .sipi_vec(sipi_vec), .cur(cur), .wake(wake),
    .clr_inhibit(clr_inhibit), .mon_reset(mon_reset), .start_load(start_load),
    .start_cs(start_cs), .start_ip(start_ip), .sipi_ignored(sipi_ignored)
  );

  assign state = cur;
endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  state,
  input logic        wake,
  input logic        clr_inhibit,
  input logic        mon_reset,
  input logic        start_load,
  input logic [15:0] start_cs,
  input logic [31:0] start_ip,
  input logic        sipi_ignored,
  input logic        sipi_valid,
  input logic [7:0]  sipi_vec,
  input logic        intr_req,
  input logic        lic_req,
  input logic        if_flag
);
  // R1: parked state is left only on a startup message
  p_park_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd4 && !sipi_valid) |=> state == 3'd4);

  // R2: enabled interrupt wakes halt or plain monitor wait
  p_irq_wake_r2: assert property (@(posedge clk) disable iff (rst)
    ((state == 3'd1 || state == 3'd2) && (intr_req || lic_req) && if_flag)
      |=> (wake && state == 3'd0));

  // R4: a wake always lands in running
  p_wake_run_r4: assert property (@(posedge clk) disable iff (rst)
    wake |-> state == 3'd0);

  // R4: inhibit clear accompanies every non-startup wake
  p_clr_inh_r4: assert property (@(posedge clk) disable iff (rst)
    (wake && !start_load) |-> clr_inhibit);

  // R5: monitor disarm only on a wake out of a monitor wait
  p_monrst_r5: assert property (@(posedge clk) disable iff (rst)
    mon_reset |-> (wake && ($past(state) == 3'd2 || $past(state) == 3'd3)));

  // R7: startup load carries the scaled vector and zero offset
  p_start_r7: assert property (@(posedge clk) disable iff (rst)
    start_load |-> (start_ip == 32'd0 && $past(state) == 3'd4 &&
                    start_cs == {$past(sipi_vec), 8'h00}));

  // R8: a stray startup message never loads
  p_stray_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_load, sipi_ignored}));

  // R11: the wake strobe never lasts two cycles
  p_one_wake_r11: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);
endmodule

bind sleep_wake_ctrl swc_checker u_chk (
  .clk(clk), .rst(rst), .state(state), .wake(wake), .clr_inhibit(clr_inhibit),
  .mon_reset(mon_reset), .start_load(start_load), .start_cs(start_cs),
  .start_ip(start_ip), .sipi_ignored(sipi_ignored), .sipi_valid(sipi_valid),
  .sipi_vec(sipi_vec), .intr_req(intr_req), .lic_req(lic_req), .if_flag(if_flag)
);

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 0, intr_req = 0, lic_req = 0, if_flag = 0;
  logic nmi_req = 0, smi_req = 0, init_req = 0, mon_hit = 0, sipi_valid = 0;
  logic [2:0] sleep_kind = 0, evt_ack = 0, mask_set = 0;
  logic [7:0] sipi_vec = 0;
  logic [2:0] state, evt_pend, evt_mask;
  logic wake, clr_inhibit, mon_reset, start_load, sipi_ignored;
  logic [15:0] start_cs;
  logic [31:0] start_ip;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_kind(sleep_kind),
    .intr_req(intr_req), .lic_req(lic_req), .if_flag(if_flag),
    .nmi_req(nmi_req), .smi_req(smi_req), .init_req(init_req),
    .evt_ack(evt_ack), .mask_set(mask_set), .mon_hit(mon_hit),
    .sipi_valid(sipi_valid), .sipi_vec(sipi_vec), .state(state), .wake(wake),
    .clr_inhibit(clr_inhibit), .mon_reset(mon_reset), .start_load(start_load),
    .start_cs(start_cs), .start_ip(start_ip), .sipi_ignored(sipi_ignored),
    .evt_pend(evt_pend), .evt_mask(evt_mask)
  );

  // {kind[2:0], if, intr, lic, mhit, exp_wake, exp_monrst}
  localparam logic [8:0] VECS [0:11] = '{
    {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  task automatic enter(input logic [2:0] k);
    sleep_req = 1'b1; sleep_kind = k;
    tick();
    sleep_req = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick();
    rst = 1'b0;
    // R10: reset state
    check("R10 state", 32'(state), 0);
    check("R10 strobes", 32'({wake, clr_inhibit, mon_reset, start_load, sipi_ignored}), 0);
    check("R10 pend", 32'(evt_pend), 0);
    check("R10 mask", 32'(evt_mask), 0);

    // table walk: R2 R5 R6 R11 and R1 for the parked row
    for (int i = 0; i < 12; i++) begin
      logic [8:0] v;
      v = VECS[i];
      do_reset();
      enter(v[8:6]);
      check("R10 entry", 32'(state), 32'(v[8:6]));
      if_flag = v[5]; intr_req = v[4]; lic_req = v[3]; mon_hit = v[2];
      tick();
      check("R2/R6 wake", 32'(wake), 32'(v[1]));
      check("R4 clr_inhibit", 32'(clr_inhibit), 32'(v[1]));
      check("R5 mon_reset", 32'(mon_reset), 32'(v[0]));
      check("R1/R4 state", 32'(state), v[1] ? 0 : 32'(v[8:6]));
      if_flag = 0; intr_req = 0; lic_req = 0; mon_hit = 0;
      tick();
      check("R11 single wake", 32'(wake), 0);
    end

    // R3: NMI wakes halt with interrupts disabled
    do_reset();
    enter(3'd1);
    nmi_req = 1; tick(); nmi_req = 0;
    check("R9 nmi latched", 32'(evt_pend), 32'h1);
    check("R3 not yet", 32'(state), 1);
    tick();
    check("R3 nmi wake", 32'(wake), 1);
    check("R3 state run", 32'(state), 0);
    check("R5 no monrst from halt", 32'(mon_reset), 0);
    evt_ack = 3'b001; tick(); evt_ack = 0;
    check("R9 ack clears", 32'(evt_pend), 0);

    // R3: masked SMI does not wake
    do_reset();
    mask_set = 3'b010; tick(); mask_set = 0;
    smi_req = 1; tick(); smi_req = 0;
    check("R9 smi latched while masked", 32'(evt_pend), 32'h2);
    enter(3'd2);
    tick();
    check("R3 masked no wake", 32'(state), 2);

    // R9: INIT refused while masked; R1: parked ignores NMI; R7 startup
    do_reset();
    mask_set = 3'b100; tick(); mask_set = 0;
    init_req = 1; tick(); init_req = 0;
    check("R9 init refused", 32'(evt_pend), 0);
    enter(3'd4);
    nmi_req = 1; intr_req = 1; if_flag = 1; mon_hit = 1;
    tick(); nmi_req = 0;
    tick();
    check("R1 parked holds", 32'(state), 4);
    intr_req = 0; if_flag = 0; mon_hit = 0;
    sipi_valid = 1; sipi_vec = 8'h9A;
    tick(); sipi_valid = 0;
    check("R7 state", 32'(state), 0);
    check("R7 start_load", 32'(start_load), 1);
    check("R7 wake", 32'(wake), 1);
    check("R7 cs", 32'(start_cs), 32'h9A00);
    check("R7 ip", 32'(start_ip), 0);
    check("R7 unmask", 32'(evt_mask), 0);
    tick();
    check("R7 load pulse ends", 32'(start_load), 0);

    // R8: startup in halt ignored
    do_reset();
    enter(3'd1);
    sipi_valid = 1; sipi_vec = 8'h12;
    tick(); sipi_valid = 0;
    check("R8 ignored flag", 32'(sipi_ignored), 1);
    check("R8 no load", 32'(start_load), 0);
    check("R8 state", 32'(state), 1);

    finish_run();
  end
endmodule